// File: doc/BRIEF.md
# Dual-Host Display Identification Store

This block holds two 128-byte banks of display identification data. Each bank is served over a two-wire serial slave interface, and there are two such interfaces, so two host computers can each be attached to their own port. Both lines of each port are sampled in one system clock domain. Each line passes a glitch filter before a per-port protocol engine decodes it. The engine answers device address 0x50, takes a one-byte word address, and supports single-byte writes, page writes of up to eight bytes, and sequential reads. Write data is collected in a page buffer and committed to the bank on STOP. A fixed write-time window follows each commit.

Static mode inputs set the operation. In dual mode the two ports run independently: port 0 reaches bank 0 and port 1 reaches bank 1, and both can read at the same time. In single mode only port 0 is live and the bank-select input picks its bank. An active-low write-protect input freezes both banks. A monitor-mode input disables both engines and links port 0 to a local CPU bus: the CPU observes the host's SCL and SDA, and the CPU's drive-low request appears on the port 0 SDA line.

Top module: `ddc_dual_edid`

## Requirements
- R1: A change on any SCL or SDA input is acted on only after it has been sampled at the same level on 3 consecutive clocks. A pulse lasting 1 or 2 clocks has no effect on the transfer.
- R2: A port acknowledges only the address byte 0xA0 (address 0x50, write) or 0xA1 (address 0x50, read). Any other address is not acknowledged, and the engine then leaves SDA released until the next START.
- R3: In dual mode, port 0 writes and reads bank 0 and port 1 writes and reads bank 1. A write of bytes d0..dn at word address a stores each byte at its own location, and a later read from a returns them.
- R4: In dual mode, both ports can run complete read transfers at the same time. Each port returns its own bank's data.
- R5: During a sequential read, the word address advances by one after each byte the host acknowledges, and it wraps from 127 to 0.
- R6: During a page write, the low 3 bits of the word address advance after each data byte and wrap within the aligned 8-byte page. A ninth or later byte overwrites the byte stored earlier at the same position.
- R7: While wp_ni is low, data bytes are still acknowledged, but no location in either bank changes.
- R8: After a STOP that ends a transfer carrying at least one data byte, the port does not acknowledge its address for WR_CYCLES clocks.
- R9: In single mode (dual_mode_i low), port 0 reaches the bank given by bank_sel_i (0 or 1). Port 1 never drives SDA and does not acknowledge.
- R10: While mon_en_i is high, neither engine responds. mon_scl_o and mon_sda_o follow the port 0 SCL and SDA inputs, and p0_sda_oe_o equals mon_sda_oe_i. While mon_en_i is low, mon_scl_o and mon_sda_o are held at 1.
- R11: After reset, both banks hold 0x00 and neither port drives SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_mode_i | input | 1 | 1: two independent ports; 0: port 0 only |
| bank_sel_i | input | 1 | Bank reached by port 0 in single mode |
| wp_ni | input | 1 | Write protect, active low |
| mon_en_i | input | 1 | Monitor mode: port 0 linked to the CPU bus |
| p0_scl_i | input | 1 | Port 0 clock line level |
| p0_sda_i | input | 1 | Port 0 data line level |
| p0_sda_oe_o | output | 1 | Port 0 pull data line low |
| p1_scl_i | input | 1 | Port 1 clock line level |
| p1_sda_i | input | 1 | Port 1 data line level |
| p1_sda_oe_o | output | 1 | Port 1 pull data line low |
| mon_scl_o | output | 1 | Port 0 clock as seen by the CPU |
| mon_sda_o | output | 1 | Port 0 data as seen by the CPU |
| mon_sda_oe_i | input | 1 | CPU request to pull port 0 data low |

## Verification
Four properties are checked on every clock. The write-protect freeze holds on the whole memory. A port in single mode or in monitor mode never drives its line. Port 0 follows the CPU drive request in monitor mode. A filtered line changes only after three agreeing samples. Bank mapping, the two wrap rules, concurrent reads, address matching, the post-write NACK window and glitch immunity span whole transfers. Only the bench scenarios show these, by comparing read-back data and acknowledge bits with a model computed from the requirements.

// File: rtl/ddc_edid_pkg.sv
package ddc_edid_pkg;
  localparam int unsigned NBANK = 2;
  localparam int unsigned NPORT = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WADR, S_WADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } slv_state_e;
endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
  parameter int unsigned STABLE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(STABLE + 1);

  logic          cand_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= 1'b1;
      cnt_q  <= CW'(STABLE);
      filt_o <= 1'b1;
    end else if (raw_i != cand_q) begin
      cand_q <= raw_i;
      cnt_q  <= CW'(1);
    end else if (cnt_q < CW'(STABLE)) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(STABLE - 1)) filt_o <= cand_q;
    end
  end
endmodule

// File: rtl/ddc_slave_engine.sv
module ddc_slave_engine
  import ddc_edid_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned PAGE_W    = 3,
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter int unsigned WR_CYCLES = 200,
  localparam int unsigned PAGE_N   = 1 << PAGE_W,
  localparam int unsigned PG_W     = ADDR_W - PAGE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic [7:0]              rd_data_i,
  output logic                    commit_o,
  output logic [PG_W-1:0]         page_o,
  output logic [PAGE_N-1:0][7:0]  pbuf_o,
  output logic [PAGE_N-1:0]       pvld_o
);
  localparam int unsigned BW = $clog2(WR_CYCLES + 1);

  slv_state_e        state_q;
  logic              scl_q, sda_q, rw_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BW-1:0]     busy_q;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire is_start = scl_i & scl_q & sda_q & ~sda_i;
  wire is_stop  = scl_i & scl_q & ~sda_q & sda_i;
  wire [PAGE_W-1:0] slot = ptr_q[PAGE_W-1:0];

  assign rd_addr_o = ptr_q;
  assign page_o    = ptr_q[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      rw_q     <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      busy_q   <= '0;
      sda_oe_o <= 1'b0;
      commit_o <= 1'b0;
      pbuf_o   <= '0;
      pvld_o   <= '0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      commit_o <= 1'b0;
      if (busy_q != '0) busy_q <= busy_q - BW'(1);
      if (!en_i) begin
        state_q  <= S_IDLE;
        sda_oe_o <= 1'b0;
        pvld_o   <= '0;
      end else if (is_start) begin
        state_q  <= S_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
        pvld_o   <= '0;
      end else if (is_stop) begin
        state_q  <= S_IDLE;
        sda_oe_o <= 1'b0;
        if (|pvld_o) begin
          commit_o <= 1'b1;
          busy_q   <= BW'(WR_CYCLES);
        end
      end else if (scl_rise) begin
        unique case (state_q)
          S_ADDR, S_WADR, S_WDAT: begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end
          S_RDAT: cnt_q <= cnt_q + 4'd1;
          S_RACK: begin
            if (sda_i) state_q <= S_IDLE;  // host NACK ends the read
            else       ptr_q   <= ptr_q + ADDR_W'(1);
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (state_q)
          S_ADDR: if (cnt_q == 4'd8) begin
            if (sh_q[7:1] == DEV_ADDR && busy_q == '0) begin
              sda_oe_o <= 1'b1;
              rw_q     <= sh_q[0];
              state_q  <= S_ADDR_ACK;
            end else begin
              state_q <= S_IDLE;
            end
          end
          S_ADDR_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q  <= S_RDAT;
              sh_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
            end else begin
              state_q  <= S_WADR;
              sda_oe_o <= 1'b0;
            end
          end
          S_WADR: if (cnt_q == 4'd8) begin
            sda_oe_o <= 1'b1;
            ptr_q    <= sh_q[ADDR_W-1:0];
            state_q  <= S_WADR_ACK;
          end
          S_WDAT: if (cnt_q == 4'd8) begin
            sda_oe_o     <= 1'b1;
            pbuf_o[slot] <= sh_q;
            pvld_o[slot] <= 1'b1;
            ptr_q        <= {ptr_q[ADDR_W-1:PAGE_W], slot + PAGE_W'(1)};
            state_q      <= S_WDAT_ACK;
          end
          S_WADR_ACK, S_WDAT_ACK: begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= S_WDAT;
          end
          S_RDAT: begin
            if (cnt_q == 4'd8) begin
              sda_oe_o <= 1'b0;
              state_q  <= S_RACK;
            end else begin
              sh_q     <= {sh_q[6:0], 1'b0};
              sda_oe_o <= ~sh_q[6];
            end
          end
          S_RACK: begin
            state_q  <= S_RDAT;
            cnt_q    <= '0;
            sh_q     <= rd_data_i;
            sda_oe_o <= ~rd_data_i[7];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddc_dual_edid.sv
module ddc_dual_edid
  import ddc_edid_pkg::*;
#(
  parameter int unsigned BANK_DEPTH = 128,
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned STABLE     = 3,
  parameter int unsigned WR_CYCLES  = 200,
  parameter logic [6:0]  DEV_ADDR   = 7'h50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dual_mode_i,
  input  logic bank_sel_i,
  input  logic wp_ni,
  input  logic mon_en_i,
  input  logic p0_scl_i,
  input  logic p0_sda_i,
  output logic p0_sda_oe_o,
  input  logic p1_scl_i,
  input  logic p1_sda_i,
  output logic p1_sda_oe_o,
  output logic mon_scl_o,
  output logic mon_sda_o,
  input  logic mon_sda_oe_i
);
  localparam int unsigned ADDR_W = $clog2(BANK_DEPTH);
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
  localparam int unsigned PG_W   = ADDR_W - PAGE_W;

  logic [NBANK-1:0][BANK_DEPTH-1:0][7:0] mem_q;

  logic [NPORT-1:0] scl_raw, sda_raw, scl_f, sda_f, eng_oe, en, live, bank_of, commit;
  logic [NPORT-1:0][ADDR_W-1:0]          rd_addr;
  logic [NPORT-1:0][7:0]                 rd_data;
  logic [NPORT-1:0][PG_W-1:0]            page;
  logic [NPORT-1:0][PAGE_BYTES-1:0][7:0] pbuf;
  logic [NPORT-1:0][PAGE_BYTES-1:0]      pvld;

  assign scl_raw = {p1_scl_i, p0_scl_i};
  assign sda_raw = {p1_sda_i, p0_sda_i};
  assign live    = {dual_mode_i, 1'b1};
  assign bank_of = {1'b1, dual_mode_i ? 1'b0 : bank_sel_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign en[p]      = live[p] & ~mon_en_i;
    assign rd_data[p] = mem_q[bank_of[p]][rd_addr[p]];

    ddc_line_filter #(.STABLE(STABLE)) i_scl_flt (
      .clk_i, .rst_ni, .raw_i(scl_raw[p]), .filt_o(scl_f[p]));
    ddc_line_filter #(.STABLE(STABLE)) i_sda_flt (
      .clk_i, .rst_ni, .raw_i(sda_raw[p]), .filt_o(sda_f[p]));

    ddc_slave_engine #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_ADDR(DEV_ADDR), .WR_CYCLES(WR_CYCLES)
    ) i_eng (
      .clk_i, .rst_ni,
      .en_i      (en[p]),
      .scl_i     (scl_f[p]),
      .sda_i     (sda_f[p]),
      .sda_oe_o  (eng_oe[p]),
      .rd_addr_o (rd_addr[p]),
      .rd_data_i (rd_data[p]),
      .commit_o  (commit[p]),
      .page_o    (page[p]),
      .pbuf_o    (pbuf[p]),
      .pvld_o    (pvld[p])
    );
  end

  // banks never collide: dual mode maps ports to distinct banks, single mode has one port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wp_ni) begin
      for (int p = 0; p < NPORT; p++) begin
        if (commit[p] && live[p]) begin
          for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pvld[p][i]) mem_q[bank_of[p]][{page[p], PAGE_W'(i)}] <= pbuf[p][i];
          end
        end
      end
    end
  end

  assign p0_sda_oe_o = mon_en_i ? mon_sda_oe_i : eng_oe[0];
  assign p1_sda_oe_o = eng_oe[1];
  assign mon_scl_o   = mon_en_i ? p0_scl_i : 1'b1;
  assign mon_sda_o   = mon_en_i ? p0_sda_i : 1'b1;
endmodule

// File: rtl/ddc_dual_edid_chk.sv
module ddc_dual_edid_chk #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned DEPTH = 128
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              dual_mode_i,
  input logic                              wp_ni,
  input logic                              mon_en_i,
  input logic                              mon_sda_oe_i,
  input logic                              p0_scl_i,
  input logic                              p0_sda_oe_o,
  input logic                              p1_sda_oe_o,
  input logic                              scl_f0,
  input logic [NBANK-1:0][DEPTH-1:0][7:0]  mem_q
);
  AST_WP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |=> $stable(mem_q)); // R7

  AST_SINGLE_P1_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_mode_i && !$past(dual_mode_i)) |-> !p1_sda_oe_o); // R9

  AST_MON_SERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_en_i |-> (p0_sda_oe_o == mon_sda_oe_i)); // R10

  AST_MON_P1_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_en_i && $past(mon_en_i)) |-> !p1_sda_oe_o); // R10

  AST_FILTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f0 != $past(scl_f0)) |-> ($past(p0_scl_i) == scl_f0 && $past(p0_scl_i, 2) == scl_f0)); // R1
endmodule

bind ddc_dual_edid ddc_dual_edid_chk #(.NBANK(2), .DEPTH(BANK_DEPTH)) i_chk (
  .clk_i, .rst_ni, .dual_mode_i, .wp_ni, .mon_en_i, .mon_sda_oe_i,
  .p0_scl_i, .p0_sda_oe_o, .p1_sda_oe_o,
  .scl_f0(scl_f[0]), .mem_q(mem_q)
);

// File: tb/test_ddc_dual_edid.sv
module test_ddc_dual_edid;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int WR_CYC = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dual = 1'b1, bsel = 1'b0, wp_n = 1'b1, mon = 1'b0, mon_oe = 1'b0;
  logic scl_d [2];
  logic sda_d [2];
  logic oe0, oe1, mscl, msda;
  logic glitch_en = 1'b0;
  wire  l0 = sda_d[0] & ~oe0;
  wire  l1 = sda_d[1] & ~oe1;

  int n_chk = 0, n_err = 0;
  int exp_mem [2][128];
  int wdat [2][16];
  int rbuf [2][130];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_dual_edid #(.WR_CYCLES(WR_CYC)) i_ddc_dual_edid (
    .clk_i(clk), .rst_ni(rst_n), .dual_mode_i(dual), .bank_sel_i(bsel), .wp_ni(wp_n),
    .mon_en_i(mon), .p0_scl_i(scl_d[0]), .p0_sda_i(l0), .p0_sda_oe_o(oe0),
    .p1_scl_i(scl_d[1]), .p1_sda_i(l1), .p1_sda_oe_o(oe1),
    .mon_scl_o(mscl), .mon_sda_o(msda), .mon_sda_oe_i(mon_oe));

  function automatic int pat(int bank, int a, int seed);
    return (a * 37 + bank * 101 + seed * 59 + 13) & 255;
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic line(int p);
    return (p == 0) ? l0 : l1;
  endfunction

  task automatic bit_out(int p, bit v);
    sda_d[p] = v; tick(Q);
    scl_d[p] = 1'b1;
    if (glitch_en) begin tick(3); scl_d[p] = 1'b0; tick(2); scl_d[p] = 1'b1; tick(5); end
    else tick(2*Q);
    scl_d[p] = 1'b0; tick(Q);
  endtask

  task automatic bit_in(int p, output bit v);
    sda_d[p] = 1'b1; tick(Q);
    scl_d[p] = 1'b1; tick(Q);
    v = line(p); tick(Q);
    scl_d[p] = 1'b0; tick(Q);
  endtask

  task automatic start_c(int p);
    sda_d[p] = 1'b1; tick(Q); scl_d[p] = 1'b1; tick(Q);
    sda_d[p] = 1'b0; tick(Q); scl_d[p] = 1'b0; tick(Q);
  endtask

  task automatic stop_c(int p);
    sda_d[p] = 1'b0; tick(Q); scl_d[p] = 1'b1; tick(Q); sda_d[p] = 1'b1; tick(Q);
  endtask

  task automatic send_byte(int p, int b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_out(p, b[i]);
    bit_in(p, r);
    ack = ~r;
  endtask

  task automatic recv_byte(int p, output int b, input bit ack);
    bit r;
    b = 0;
    for (int i = 0; i < 8; i++) begin bit_in(p, r); b = (b << 1) | int'(r); end
    bit_out(p, ~ack);
  endtask

  // returns number of acknowledged bytes (address, word address, data)
  task automatic wr_txn(int p, int wa, int n, output int acks);
    bit a;
    acks = 0;
    start_c(p);
    send_byte(p, 8'hA0, a); acks += int'(a);
    send_byte(p, wa, a);    acks += int'(a);
    for (int i = 0; i < n; i++) begin send_byte(p, wdat[p][i], a); acks += int'(a); end
    stop_c(p);
  endtask

  task automatic rd_txn(int p, int wa, int n, output int acks);
    bit a;
    int b;
    acks = 0;
    start_c(p);
    send_byte(p, 8'hA0, a); acks += int'(a);
    send_byte(p, wa, a);    acks += int'(a);
    start_c(p);
    send_byte(p, 8'hA1, a); acks += int'(a);
    for (int i = 0; i < n; i++) begin recv_byte(p, b, i != n - 1); rbuf[p][i] = b; end
    stop_c(p);
  endtask

  task automatic probe(int p, int addr_byte, output bit ack);
    start_c(p);
    send_byte(p, addr_byte, ack);
    stop_c(p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R1..R11 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int a0, a1, wa;
    bit ak;
    for (int p = 0; p < 2; p++) begin scl_d[p] = 1'b1; sda_d[p] = 1'b1; end
    for (int b = 0; b < 2; b++) for (int i = 0; i < 128; i++) exp_mem[b][i] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R11 p0 idle drive", int'(oe0), 0);
    chk("R11 p1 idle drive", int'(oe1), 0);
    chk("R10 mon_scl idle", int'(mscl), 1);
    chk("R10 mon_sda idle", int'(msda), 1);
    rd_txn(0, 0, 1, a0);
    chk("R11 reset content", rbuf[0][0], 0);

    // R2: foreign addresses
    probe(0, 8'hA2, ak); chk("R2 addr 0x51 nack", int'(ak), 0);
    probe(1, 8'h40, ak); chk("R2 addr 0x20 nack", int'(ak), 0);

    // R3: full-bank page sweep on both ports concurrently
    for (int pg = 0; pg < 16; pg++) begin
      for (int i = 0; i < 8; i++) begin
        wdat[0][i] = pat(0, pg*8 + i, 0);
        wdat[1][i] = pat(1, pg*8 + i, 0);
        exp_mem[0][pg*8 + i] = wdat[0][i];
        exp_mem[1][pg*8 + i] = wdat[1][i];
      end
      fork
        wr_txn(0, pg*8, 8, a0);
        wr_txn(1, pg*8, 8, a1);
      join
      chk("R3 p0 write acks", a0, 10);
      chk("R3 p1 write acks", a1, 10);
      tick(WR_CYC + 20);
    end

    // R4: concurrent full reads
    fork
      rd_txn(0, 0, 128, a0);
      rd_txn(1, 0, 128, a1);
    join
    chk("R4 p0 read acks", a0, 3);
    chk("R4 p1 read acks", a1, 3);
    for (int i = 0; i < 128; i++) begin
      chk("R3/R4 bank0 data", rbuf[0][i], exp_mem[0][i]);
      chk("R3/R4 bank1 data", rbuf[1][i], exp_mem[1][i]);
    end

    // R8: busy window after write
    wdat[0][0] = 8'h5A; exp_mem[0][10] = 8'h5A;
    wr_txn(0, 10, 1, a0);
    probe(0, 8'hA0, ak); chk("R8 nack during write time", int'(ak), 0);
    tick(WR_CYC + 20);
    probe(0, 8'hA0, ak); chk("R8 ack after write time", int'(ak), 1);
    rd_txn(0, 10, 1, a0); chk("R3 single byte", rbuf[0][0], 8'h5A);

    // R6: page wrap, 10 bytes from offset 5 of page 0x18
    wa = 8'h1D;
    for (int i = 0; i < 10; i++) begin
      wdat[0][i] = pat(0, i, 3);
      exp_mem[0][(wa & ~7) | ((wa + i) & 7)] = wdat[0][i];
    end
    wr_txn(0, wa, 10, a0); chk("R6 all acked", a0, 12);
    tick(WR_CYC + 20);
    rd_txn(0, 8'h18, 9, a0);
    for (int i = 0; i < 9; i++) chk("R6 page wrap data", rbuf[0][i], exp_mem[0][(8'h18 + i) & 127]);

    // R5: read wrap 127 -> 0
    rd_txn(1, 126, 4, a1);
    for (int i = 0; i < 4; i++) chk("R5 read wrap", rbuf[1][i], exp_mem[1][(126 + i) % 128]);

    // R7: write protect
    wp_n = 1'b0;
    for (int i = 0; i < 3; i++) wdat[1][i] = 8'hC3 ^ i;
    wr_txn(1, 40, 3, a1); chk("R7 protected bytes acked", a1, 5);
    tick(WR_CYC + 20);
    wp_n = 1'b1;
    rd_txn(1, 40, 3, a1);
    for (int i = 0; i < 3; i++) chk("R7 array unchanged", rbuf[1][i], exp_mem[1][40 + i]);

    // R1: 2-clock SCL glitches inside every driven bit
    glitch_en = 1'b1;
    rd_txn(0, 64, 4, a0);
    glitch_en = 1'b0;
    chk("R1 acks with glitches", a0, 3);
    for (int i = 0; i < 4; i++) chk("R1 data with glitches", rbuf[0][i], exp_mem[0][64 + i]);

    // R9: single mode
    dual = 1'b0; bsel = 1'b1; tick(10);
    wdat[0][0] = 8'h11; wdat[0][1] = 8'h22;
    exp_mem[1][100] = 8'h11; exp_mem[1][101] = 8'h22;
    wr_txn(0, 100, 2, a0); chk("R9 p0 write acks", a0, 4);
    tick(WR_CYC + 20);
    rd_txn(0, 100, 2, a0);
    chk("R9 bank1 via p0 b0", rbuf[0][0], 8'h11);
    chk("R9 bank1 via p0 b1", rbuf[0][1], 8'h22);
    probe(1, 8'hA0, ak); chk("R9 p1 ignored", int'(ak), 0);
    bsel = 1'b0; tick(10);
    rd_txn(0, 100, 2, a0);
    chk("R9 bank0 via p0", rbuf[0][0], exp_mem[0][100]);
    chk("R9 bank0 via p0 next", rbuf[0][1], exp_mem[0][101]);
    dual = 1'b1; tick(10);
    rd_txn(1, 100, 1, a1); chk("R3 bank1 after single mode", rbuf[1][0], 8'h11);

    // R10: monitor mode
    mon = 1'b1; tick(10);
    probe(0, 8'hA0, ak); chk("R10 engine silent", int'(ak), 0);
    sda_d[0] = 1'b0; tick(2);
    chk("R10 mon sees sda low", int'(msda), 0);
    chk("R10 mon sees scl", int'(mscl), int'(scl_d[0]));
    sda_d[0] = 1'b1; mon_oe = 1'b1; tick(2);
    chk("R10 cpu pulls line", int'(l0), 0);
    mon_oe = 1'b0; tick(2);
    chk("R10 cpu releases line", int'(l0), 1);
    mon = 1'b0; tick(10);
    chk("R10 mon_sda held high", int'(msda), 1);
    rd_txn(0, 10, 1, a0); chk("R10 engine back", rbuf[0][0], 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule